// File: doc/BRIEF.md
# Exception Entry Vector Generator

This block sits beside the program-counter logic of a processor pipeline. When the pipeline accepts an exception it raises a one-cycle request together with the exception kind and the machine context: the faulting PC, the compressed-ISA bit, the delay-slot flags, the status bits and the interrupt-vector configuration. On the next clock edge the block presents a registered bundle of updates. The bundle holds the handler address, the return address and which save register takes it, the branch-delay bit, the 5-bit exception code, and strobes that set EXL, set ERL and BEV, enter debug mode or force kernel mode.

The handler address comes from a base and an offset. The base is a fixed boot vector or the software exception base. The offset depends on the exception kind, the refill flag, EXL, BEV and the interrupt-vector settings. Reset-class and debug exceptions go to fixed addresses and have their own save registers. The owning status and coprocessor registers apply the strobes. The block keeps no architectural state of its own.

Top module: `exc_vec_top`

## Requirements
- R1: The return address `savedPc` is `curPc` OR'd with `isaMode` in bit 0. When `inDelaySlot` is set it is reduced by 2 if `delayIs16` is set, and by 4 otherwise.
- R2: If `statusExl` is high at the request, a general exception does not set EXL, writes neither the EPC nor the branch-delay bit, and does not force kernel mode. `saveDest` is 0 (none). The handler PC and the exception code are still produced.
- R3: The general base is 0xBFC00200 when `statusBev` is set, and otherwise `ebase` with bits [9:0] cleared. Kinds without a special offset add 0x180.
- R4: TLB load (kind 2) and TLB store (kind 3) with `refillMiss` set and `statusExl` clear use offset 0x000. With `statusExl` set they use 0x180.
- R5: An interrupt (kind 0) with neither vectored mode enabled uses offset 0x200 when `ivBit` is set and 0x180 when it is clear.
- R6: When `vecIntEn` is set, the interrupt offset is 0x200 + v × (`vecSpacing` × 32). Here v is the highest set bit, searched from 7 down to 1, of `irqPending & irqMask`, and v is 0 when none of those bits is set.
- R7: When only `vecExtEn` is set, v is the whole value `irqPending & irqMask`. `vecIntEn` takes precedence when both are set.
- R8: A cache error (kind 14) uses offset 0x100 when `statusBev` is set and 0x20000100 when it is clear.
- R9: NMI (kind 6) and soft reset (kind 7) jump to 0xBFC00000. They save the return address to the error EPC (`saveDest` = 2), pulse `setErlBev` and force kernel mode.
- R10: A debug exception (kind 15) jumps to 0xBFC00480. It saves the return address to the debug PC (`saveDest` = 3), pulses `enterDebug` and forces kernel mode.
- R11: A general exception writes `excCode` with these codes: interrupt 0, modify 1, TLB load 2, TLB store 3, address error load 4, address error store 5, syscall 8, break 9, reserved instruction 10, coprocessor unusable 11, overflow 12, trap 13, cache error 30. The kind encoding equals the code for every kind except cache error, which is kind 14.
- R12: All outputs are zero after reset. A request updates the outputs at the next clock edge and pulses `updValid` for exactly that cycle. Strobe outputs are zero in any other cycle, and the value outputs hold.
- R13: With EXL clear, a general exception pulses `setExl` and `forceKernel` and writes `causeBd` = `inDelaySlot` with `causeBdWe` high. NMI, soft reset and debug exceptions write `causeBd` = 0 when EXL is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excReq | input | 1 | Exception accepted this cycle |
| excKind | input | 4 | Exception kind encoding |
| curPc | input | 32 | PC of the faulting instruction |
| isaMode | input | 1 | Compressed-ISA mode bit |
| inDelaySlot | input | 1 | Faulting instruction sits in a delay slot |
| delayIs16 | input | 1 | The branch owning the slot is 16-bit |
| statusExl | input | 1 | Current EXL bit |
| statusBev | input | 1 | Current BEV bit |
| refillMiss | input | 1 | TLB miss is a refill |
| ivBit | input | 1 | Interrupts use the dedicated vector |
| vecIntEn | input | 1 | Internally vectored interrupts |
| vecExtEn | input | 1 | Externally supplied interrupt vector |
| vecSpacing | input | 5 | Vector spacing in units of 32 bytes |
| irqPending | input | 8 | Pending interrupt lines |
| irqMask | input | 8 | Interrupt mask bits |
| ebase | input | 32 | Software exception base |
| updValid | output | 1 | Update bundle valid |
| newPc | output | 32 | Handler address |
| saveDest | output | 2 | 0 none, 1 EPC, 2 error EPC, 3 debug PC |
| savedPc | output | 32 | Return address to save |
| causeBdWe | output | 1 | Write branch-delay bit |
| causeBd | output | 1 | Branch-delay bit value |
| excCodeWe | output | 1 | Write exception code field |
| excCode | output | 5 | Exception code |
| setExl | output | 1 | Set EXL |
| setErlBev | output | 1 | Set ERL and BEV |
| enterDebug | output | 1 | Enter debug mode |
| forceKernel | output | 1 | Force kernel mode |

## Verification
The vectored-interrupt offsets are the hardest results to reach from the ports. They need the right mix of pending and masked lines, a nonzero spacing, and both vector-mode enables, and the internal mode must ignore bit 0. The stimulus drives masked patterns whose highest bit differs from the highest raw pending bit, and a pattern with only bit 0 set. It also drives both enables together to show that internal mode wins. The refill offset and the EXL guard are exercised in pairs that differ only in EXL, so each pair isolates the effect of that one bit.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

  typedef enum logic [3:0] {
    EXC_INT    = 4'd0,
    EXC_MOD    = 4'd1,
    EXC_TLBL   = 4'd2,
    EXC_TLBS   = 4'd3,
    EXC_ADEL   = 4'd4,
    EXC_ADES   = 4'd5,
    EXC_NMI    = 4'd6,
    EXC_SRESET = 4'd7,
    EXC_SYS    = 4'd8,
    EXC_BRK    = 4'd9,
    EXC_RI     = 4'd10,
    EXC_CPU    = 4'd11,
    EXC_OV     = 4'd12,
    EXC_TRAP   = 4'd13,
    EXC_CACHE  = 4'd14,
    EXC_DEBUG  = 4'd15
  } excKind_e;

  typedef enum logic [1:0] {
    SAVE_NONE = 2'd0,
    SAVE_EPC  = 2'd1,
    SAVE_ERR  = 2'd2,
    SAVE_DBG  = 2'd3
  } saveDest_e;

  typedef enum logic [2:0] {
    VSEL_GENERAL = 3'd0,
    VSEL_REFILL  = 3'd1,
    VSEL_IRQ     = 3'd2,
    VSEL_CACHE   = 3'd3,
    VSEL_RESET   = 3'd4,
    VSEL_DEBUG   = 3'd5
  } vecSel_e;

  typedef struct packed {
    logic      take;
    saveDest_e dest;
    logic      bdWe;
    logic      bdFromSlot;
    logic      codeWe;
    logic [4:0] code;
    logic      setExl;
    logic      setErlBev;
    logic      enterDebug;
    logic      forceKernel;
    vecSel_e   vecSel;
  } excCtl_t;

  localparam logic [31:0] RESET_VECTOR  = 32'hBFC0_0000;
  localparam logic [31:0] BOOT_GEN_BASE = 32'hBFC0_0200;
  localparam logic [31:0] DEBUG_VECTOR  = 32'hBFC0_0480;
  localparam logic [31:0] OFS_DEFAULT   = 32'h0000_0180;
  localparam logic [31:0] OFS_IRQ       = 32'h0000_0200;
  localparam logic [31:0] OFS_CACHE_BEV = 32'h0000_0100;
  localparam logic [31:0] OFS_CACHE_RUN = 32'h2000_0100;
  localparam logic [4:0]  CODE_CACHE    = 5'd30;

endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_vec_pkg::*;
(
  input  logic     excReq,
  input  excKind_e kind,
  input  logic     statusExl,
  input  logic     refillMiss,
  output excCtl_t  ctl
);

  logic isResetClass;
  logic isDebug;
  logic isTlbMiss;

  assign isResetClass = (kind == EXC_NMI) || (kind == EXC_SRESET);
  assign isDebug      = (kind == EXC_DEBUG);
  assign isTlbMiss    = (kind == EXC_TLBL) || (kind == EXC_TLBS);

  always_comb begin
    ctl = '0;
    if (excReq) begin
      ctl.take = 1'b1;
      ctl.bdWe = !statusExl;
      if (isResetClass) begin
        ctl.dest        = SAVE_ERR;
        ctl.setErlBev   = 1'b1;
        ctl.forceKernel = 1'b1;
        ctl.vecSel      = VSEL_RESET;
      end else if (isDebug) begin
        ctl.dest        = SAVE_DBG;
        ctl.enterDebug  = 1'b1;
        ctl.forceKernel = 1'b1;
        ctl.vecSel      = VSEL_DEBUG;
      end else begin
        ctl.dest        = statusExl ? SAVE_NONE : SAVE_EPC;
        ctl.bdFromSlot  = 1'b1;
        ctl.codeWe      = 1'b1;
        ctl.code        = (kind == EXC_CACHE) ? CODE_CACHE : {1'b0, kind};
        ctl.setExl      = !statusExl;
        ctl.forceKernel = !statusExl;
        if (kind == EXC_INT)
          ctl.vecSel = VSEL_IRQ;
        else if (kind == EXC_CACHE)
          ctl.vecSel = VSEL_CACHE;
        else if (isTlbMiss && refillMiss && !statusExl)
          ctl.vecSel = VSEL_REFILL;
        else
          ctl.vecSel = VSEL_GENERAL;
      end
    end
  end

endmodule

// File: rtl/exc_datapath.sv
module exc_datapath
  import exc_vec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IRQ_W  = 8,
  parameter int SPC_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  excCtl_t           ctl,
  input  logic [ADDR_W-1:0] curPc,
  input  logic              isaMode,
  input  logic              inDelaySlot,
  input  logic              delayIs16,
  input  logic              statusBev,
  input  logic              ivBit,
  input  logic              vecIntEn,
  input  logic              vecExtEn,
  input  logic [SPC_W-1:0]  vecSpacing,
  input  logic [IRQ_W-1:0]  irqPending,
  input  logic [IRQ_W-1:0]  irqMask,
  input  logic [ADDR_W-1:0] ebase,
  output logic              updValid,
  output logic [ADDR_W-1:0] newPc,
  output logic [1:0]        saveDest,
  output logic [ADDR_W-1:0] savedPc,
  output logic              causeBdWe,
  output logic              causeBd,
  output logic              excCodeWe,
  output logic [4:0]        excCode,
  output logic              setExl,
  output logic              setErlBev,
  output logic              enterDebug,
  output logic              forceKernel
);

  localparam int BASE_CLR = 10;

  function automatic logic [IRQ_W-1:0] topLine(input logic [IRQ_W-1:0] lines);
    logic [IRQ_W-1:0] idx;
    idx = '0;
    for (int i = 1; i < IRQ_W; i++)
      if (lines[i]) idx = IRQ_W'(i);
    return idx;
  endfunction

  logic [IRQ_W-1:0]  irqLive;
  logic [IRQ_W-1:0]  vecNum;
  logic [ADDR_W-1:0] spacingBytes;
  logic [ADDR_W-1:0] irqOffset;
  logic [ADDR_W-1:0] genBase;
  logic [ADDR_W-1:0] handlerPc;
  logic [ADDR_W-1:0] retAddr;
  logic [ADDR_W-1:0] slotBackup;

  assign irqLive      = irqPending & irqMask;
  assign vecNum       = vecIntEn ? topLine(irqLive) : irqLive;
  assign spacingBytes = ADDR_W'({vecSpacing, 5'b0});

  always_comb begin
    if (vecIntEn || vecExtEn)
      irqOffset = ADDR_W'(OFS_IRQ) + ADDR_W'(vecNum) * spacingBytes;
    else if (ivBit)
      irqOffset = ADDR_W'(OFS_IRQ);
    else
      irqOffset = ADDR_W'(OFS_DEFAULT);
  end

  assign genBase = statusBev ? ADDR_W'(BOOT_GEN_BASE)
                             : {ebase[ADDR_W-1:BASE_CLR], {BASE_CLR{1'b0}}};

  always_comb begin
    case (ctl.vecSel)
      VSEL_REFILL: handlerPc = genBase;
      VSEL_IRQ:    handlerPc = genBase + irqOffset;
      VSEL_CACHE:  handlerPc = genBase + (statusBev ? ADDR_W'(OFS_CACHE_BEV)
                                                    : ADDR_W'(OFS_CACHE_RUN));
      VSEL_RESET:  handlerPc = ADDR_W'(RESET_VECTOR);
      VSEL_DEBUG:  handlerPc = ADDR_W'(DEBUG_VECTOR);
      default:     handlerPc = genBase + ADDR_W'(OFS_DEFAULT);
    endcase
  end

  assign slotBackup = !inDelaySlot ? '0 : (delayIs16 ? ADDR_W'(2) : ADDR_W'(4));
  assign retAddr    = (curPc | ADDR_W'(isaMode)) - slotBackup;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      updValid    <= 1'b0;
      newPc       <= '0;
      saveDest    <= SAVE_NONE;
      savedPc     <= '0;
      causeBdWe   <= 1'b0;
      causeBd     <= 1'b0;
      excCodeWe   <= 1'b0;
      excCode     <= '0;
      setExl      <= 1'b0;
      setErlBev   <= 1'b0;
      enterDebug  <= 1'b0;
      forceKernel <= 1'b0;
    end else begin
      updValid    <= ctl.take;
      saveDest    <= ctl.dest;
      causeBdWe   <= ctl.bdWe;
      excCodeWe   <= ctl.codeWe;
      setExl      <= ctl.setExl;
      setErlBev   <= ctl.setErlBev;
      enterDebug  <= ctl.enterDebug;
      forceKernel <= ctl.forceKernel;
      if (ctl.take)                newPc   <= handlerPc;
      if (ctl.dest != SAVE_NONE)   savedPc <= retAddr;
      if (ctl.bdWe)                causeBd <= ctl.bdFromSlot & inDelaySlot;
      if (ctl.codeWe)              excCode <= ctl.code;
    end
  end

  AST_RET_NO_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.take && (ctl.dest != SAVE_NONE) && !inDelaySlot
      |=> savedPc == ($past(curPc) | ADDR_W'($past(isaMode)))); // R1

  AST_RESET_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    ctl.take && (ctl.vecSel == VSEL_RESET) |=> newPc == ADDR_W'(RESET_VECTOR)); // R9

  AST_DEBUG_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    ctl.take && (ctl.vecSel == VSEL_DEBUG) |=> newPc == ADDR_W'(DEBUG_VECTOR)); // R10

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    updValid |-> newPc[1:0] == 2'b00); // R3

endmodule

// File: rtl/exc_vec_top.sv
module exc_vec_top
  import exc_vec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IRQ_W  = 8,
  parameter int SPC_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excReq,
  input  logic [3:0]        excKind,
  input  logic [ADDR_W-1:0] curPc,
  input  logic              isaMode,
  input  logic              inDelaySlot,
  input  logic              delayIs16,
  input  logic              statusExl,
  input  logic              statusBev,
  input  logic              refillMiss,
  input  logic              ivBit,
  input  logic              vecIntEn,
  input  logic              vecExtEn,
  input  logic [SPC_W-1:0]  vecSpacing,
  input  logic [IRQ_W-1:0]  irqPending,
  input  logic [IRQ_W-1:0]  irqMask,
  input  logic [ADDR_W-1:0] ebase,
  output logic              updValid,
  output logic [ADDR_W-1:0] newPc,
  output logic [1:0]        saveDest,
  output logic [ADDR_W-1:0] savedPc,
  output logic              causeBdWe,
  output logic              causeBd,
  output logic              excCodeWe,
  output logic [4:0]        excCode,
  output logic              setExl,
  output logic              setErlBev,
  output logic              enterDebug,
  output logic              forceKernel
);

  excCtl_t ctlBus;

  exc_ctrl uCtrl (
    .excReq     (excReq),
    .kind       (excKind_e'(excKind)),
    .statusExl  (statusExl),
    .refillMiss (refillMiss),
    .ctl        (ctlBus)
  );

  exc_datapath #(.ADDR_W(ADDR_W), .IRQ_W(IRQ_W), .SPC_W(SPC_W)) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctlBus),
    .curPc       (curPc),
    .isaMode     (isaMode),
    .inDelaySlot (inDelaySlot),
    .delayIs16   (delayIs16),
    .statusBev   (statusBev),
    .ivBit       (ivBit),
    .vecIntEn    (vecIntEn),
    .vecExtEn    (vecExtEn),
    .vecSpacing  (vecSpacing),
    .irqPending  (irqPending),
    .irqMask     (irqMask),
    .ebase       (ebase),
    .updValid    (updValid),
    .newPc       (newPc),
    .saveDest    (saveDest),
    .savedPc     (savedPc),
    .causeBdWe   (causeBdWe),
    .causeBd     (causeBd),
    .excCodeWe   (excCodeWe),
    .excCode     (excCode),
    .setExl      (setExl),
    .setErlBev   (setErlBev),
    .enterDebug  (enterDebug),
    .forceKernel (forceKernel)
  );

  AST_EXL_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    excReq && statusExl |=> !setExl && (saveDest != 2'd1) && !causeBdWe); // R2

  AST_PULSE_ON: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> updValid); // R12

  AST_PULSE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !excReq |=> !updValid && $stable(newPc) && $stable(excCode)); // R12

  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({setExl, setErlBev, enterDebug})); // R13

endmodule

// File: tb/tb_exc_vec_top.sv
module tb_exc_vec_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        excReq = 1'b0;
  logic [3:0]  excKind = '0;
  logic [31:0] curPc = '0;
  logic        isaMode = 1'b0, inDelaySlot = 1'b0, delayIs16 = 1'b0;
  logic        statusExl = 1'b0, statusBev = 1'b1, refillMiss = 1'b0;
  logic        ivBit = 1'b0, vecIntEn = 1'b0, vecExtEn = 1'b0;
  logic [4:0]  vecSpacing = '0;
  logic [7:0]  irqPending = '0, irqMask = '0;
  logic [31:0] ebase = '0;

  logic        updValid, causeBdWe, causeBd, excCodeWe;
  logic        setExl, setErlBev, enterDebug, forceKernel;
  logic [31:0] newPc, savedPc;
  logic [1:0]  saveDest;
  logic [4:0]  excCode;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [31:0] mPc = '0, mSaved = '0;
  logic        mBd = 1'b0;
  logic [4:0]  mCode = '0;
  logic [11:0] mStrobe = '0;

  always #5 clk = ~clk;

  exc_vec_top dut (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excKind(excKind), .curPc(curPc),
    .isaMode(isaMode), .inDelaySlot(inDelaySlot), .delayIs16(delayIs16),
    .statusExl(statusExl), .statusBev(statusBev), .refillMiss(refillMiss),
    .ivBit(ivBit), .vecIntEn(vecIntEn), .vecExtEn(vecExtEn),
    .vecSpacing(vecSpacing), .irqPending(irqPending), .irqMask(irqMask),
    .ebase(ebase), .updValid(updValid), .newPc(newPc), .saveDest(saveDest),
    .savedPc(savedPc), .causeBdWe(causeBdWe), .causeBd(causeBd),
    .excCodeWe(excCodeWe), .excCode(excCode), .setExl(setExl),
    .setErlBev(setErlBev), .enterDebug(enterDebug), .forceKernel(forceKernel)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural model of one clock: compute expectation from driven inputs
  task automatic modelClock();
    int kind;
    logic [31:0] base, off, ret;
    logic [7:0] live;
    int v;
    bit gen, isErr, isDbg;
    logic [1:0] dest;
    kind = int'(excKind);
    if (!excReq) begin
      mStrobe = '0;
      return;
    end
    isErr = (kind == 6) || (kind == 7);
    isDbg = (kind == 15);
    gen   = !isErr && !isDbg;
    ret = (curPc | {31'd0, isaMode});
    if (inDelaySlot) ret = ret - (delayIs16 ? 32'd2 : 32'd4);
    base = statusBev ? 32'hBFC00200 : (ebase & ~32'h3FF);
    off = 32'h180;
    if ((kind == 2 || kind == 3) && refillMiss && !statusExl) off = 32'h0;
    if (kind == 0) begin
      live = irqPending & irqMask;
      if (vecIntEn || vecExtEn) begin
        v = 0;
        if (vecIntEn) begin
          for (int b = 7; b >= 1; b--) if (live[b] && v == 0) v = b;
        end else v = int'(live);
        off = 32'h200 + 32'(v) * 32'(vecSpacing) * 32;
      end else if (ivBit) off = 32'h200;
    end
    if (kind == 14) off = statusBev ? 32'h100 : 32'h20000100;
    if (isErr)      mPc = 32'hBFC00000;
    else if (isDbg) mPc = 32'hBFC00480;
    else            mPc = base + off;
    dest = gen ? (statusExl ? 2'd0 : 2'd1) : (isErr ? 2'd2 : 2'd3);
    if (dest != 2'd0) mSaved = ret;
    if (!statusExl) mBd = gen ? inDelaySlot : 1'b0;
    if (gen) mCode = (kind == 14) ? 5'd30 : 5'(kind);
    // strobe word: valid,dest[1:0],bdWe,codeWe,setExl,setErlBev,enterDebug,forceKernel
    mStrobe = {3'b0, 1'b1, dest, !statusExl, gen, gen && !statusExl, isErr, isDbg,
               isErr || isDbg || (gen && !statusExl)};
  endtask

  task automatic step(input string tag);
    modelClock();
    @(posedge clk);
    @(negedge clk);
    check(tag, "newPc", newPc, mPc);
    check(tag, "savedPc", savedPc, mSaved);
    check(tag, "strobes", {20'd0, 3'b0, updValid, saveDest, causeBdWe, excCodeWe,
          setExl, setErlBev, enterDebug, forceKernel}, {20'd0, mStrobe});
    check(tag, "bd/code", {26'd0, causeBd, excCode}, {26'd0, mBd, mCode});
    excReq = 1'b0;
  endtask

  task automatic fire(input int kind, input logic [31:0] pc, input string tag);
    excKind = 4'(kind);
    curPc   = pc;
    excReq  = 1'b1;
    step(tag);
  endtask

  initial begin
    #(20000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12", "reset newPc", newPc, 32'h0);
    check("R12", "reset strobes", {updValid, saveDest, causeBdWe, excCodeWe, setExl,
          setErlBev, enterDebug, forceKernel}, 32'h0);
    rstN = 1'b1;
    step("R12");
    // general kinds, boot base
    fire(8, 32'h8000_1000, "R3");
    fire(8, 32'h8000_1000, "R11");
    isaMode = 1'b1;
    fire(9, 32'h0040_0200, "R1");
    inDelaySlot = 1'b1;
    fire(10, 32'h0040_0300, "R1");
    delayIs16 = 1'b1;
    fire(1, 32'h0040_0406, "R13");
    inDelaySlot = 1'b0; delayIs16 = 1'b0; isaMode = 1'b0;
    // run-time base
    statusBev = 1'b0; ebase = 32'h8000_1234;
    fire(12, 32'h1000, "R3");
    // EXL guard
    statusExl = 1'b1; inDelaySlot = 1'b1;
    fire(13, 32'h2000, "R2");
    inDelaySlot = 1'b0;
    // refill
    refillMiss = 1'b1;
    fire(2, 32'h3000, "R4");
    statusExl = 1'b0;
    fire(2, 32'h3000, "R4");
    fire(3, 32'h3004, "R4");
    refillMiss = 1'b0;
    fire(3, 32'h3008, "R4");
    // interrupts
    fire(0, 32'h4000, "R5");
    ivBit = 1'b1;
    fire(0, 32'h4000, "R5");
    vecIntEn = 1'b1; vecSpacing = 5'd2;
    irqPending = 8'b1010_0110; irqMask = 8'b0010_0111;
    fire(0, 32'h4004, "R6");
    irqPending = 8'b0000_0001; irqMask = 8'hFF;
    fire(0, 32'h4008, "R6");
    vecIntEn = 1'b0; vecExtEn = 1'b1; vecSpacing = 5'd1;
    irqPending = 8'h3B; irqMask = 8'h1F;
    fire(0, 32'h400C, "R7");
    vecIntEn = 1'b1;
    fire(0, 32'h4010, "R7");
    vecIntEn = 1'b0; vecExtEn = 1'b0; ivBit = 1'b0;
    // cache error
    fire(14, 32'h5000, "R8");
    statusBev = 1'b1;
    fire(14, 32'h5000, "R8");
    // reset class and debug
    isaMode = 1'b1; inDelaySlot = 1'b1;
    fire(6, 32'h6000, "R9");
    fire(7, 32'h6100, "R9");
    fire(15, 32'h7000, "R10");
    statusExl = 1'b1;
    fire(15, 32'h7100, "R10");
    statusExl = 1'b0; isaMode = 1'b0; inDelaySlot = 1'b0;
    // all general codes
    for (int k = 0; k < 16; k++) begin
      if (k != 6 && k != 7 && k != 15) fire(k, 32'h9000 + 32'(k * 4), "R11");
    end
    // idle cycles hold values
    repeat (3) step("R12");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule